// File: doc/BRIEF.md
# ECC Control and Error Status Register Pair

This block is the host-visible register pair of a memory error-correction unit. A read/write control/status register holds the interrupt enables for single-bit and double-bit errors, a correction-inhibit bit, a capture mode bit, the sticky error flags and a power-fail flag. A read-only error status register records the syndrome and the memory bank of a reported error. The error-correcting datapath is outside the block. It only reports errors through one strobe per error class, which carries a syndrome and a bank number.

The host reaches the pair with I/O read and write strobes. A base-address match input qualifies every access, and one register-select address bit picks the register. Reads are combinational from the current register state. Writes take effect at the next clock edge. The block drives one interrupt request per error class, and it exports the correction-inhibit and capture mode bits to the datapath.

Top module: `ecc_status_regs`

## Requirements
- R1: An access happens only while `base_hit` is 1 and the matching strobe is 1. A write without `base_hit` changes nothing. `rdata` is 0 whenever no qualified read is in progress.
- R2: The CSR is selected by `reg_sel`=1. It reads as bit7 double-error flag, bit6 single-error flag, bit5 constant 0, bit4 power-fail flag, bit3 capture mode, bit2 correction inhibit, bit1 double-error enable, bit0 single-error enable.
- R3: A CSR write stores bit0 as the single-error enable, bit1 as the double-error enable, bit2 as the correction inhibit and bit3 as the capture mode. Bits 7:5 are ignored. Bit4=1 clears the power-fail flag, and bit4 is not stored.
- R4: An error flag is set by its strobe only while its enable is 1. A strobe while the enable is 0 leaves the flag at 0. A CSR write that puts the enable to 0 clears the flag.
- R5: `irq_sbe` and `irq_dbe` are 1 exactly when the matching flag and enable are both 1.
- R6: With capture mode 1, the ESR takes only the first error and holds it against later errors. A CSR write with bit3=1 re-arms capture for the next error. With capture mode 0, every error strobe reloads the ESR.
- R7: The ESR is selected by `reg_sel`=0. It reads as bit7 bank[1], bit6 bank[0], and bits 5:0 syndrome. Write data never loads it.
- R8: A qualified write to the ESR clears it to 0.
- R9: A rising edge on `pwr_fail` sets the power-fail flag, and the flag stays set until a CSR write with bit4=1.
- R10: `rst_n` low, or `init` high at a clock edge, clears every control bit, flag and the ESR to 0, and re-arms capture.
- R11: A clearing write wins over an event in the same cycle. This covers an enable-clear against an error strobe, an ESR write against an error strobe, and a bit4 write against a power-fail edge.
- R12: `corr_inhibit` and `latch_first` follow the stored CSR bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous clear of all state |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| reg_sel | input | 1 | 1 selects the CSR, 0 selects the ESR |
| base_hit | input | 1 | Base-address match qualifying the access |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| sbe_stb | input | 1 | Single-bit error reported this cycle |
| dbe_stb | input | 1 | Double-bit error reported this cycle |
| err_syn | input | 6 | Syndrome of the reported error |
| err_bank | input | 2 | Bank of the reported error |
| pwr_fail | input | 1 | Power-fail sense input |
| irq_sbe | output | 1 | Single-bit error interrupt request |
| irq_dbe | output | 1 | Double-bit error interrupt request |
| corr_inhibit | output | 1 | Correction inhibit to the datapath |
| latch_first | output | 1 | Capture mode bit |

## Verification
Three pairs of functions can fall in the same clock cycle. A host write that clears state can meet an error strobe, or an ESR clear can meet a capture, or a power-fail clear can meet a new power-fail edge. Directed steps drive each pair in one cycle on purpose. Random stimulus then makes these collisions often, because strobes, writes and `pwr_fail` toggles are all driven freely. Each result is judged by reading the CSR and ESR back through the host port in the next cycle, and by comparing the interrupt outputs with a bench model that always gives the clearing write priority.

// File: rtl/ecc_reg_pkg.sv
package ecc_reg_pkg;
   localparam int N_ERR        = 2;
   localparam int ERR_SBE      = 0;
   localparam int ERR_DBE      = 1;
   localparam int CSR_SBE_EN   = 0;
   localparam int CSR_DBE_EN   = 1;
   localparam int CSR_INHIBIT  = 2;
   localparam int CSR_LATCH    = 3;
   localparam int CSR_PF       = 4;
   localparam int CSR_SBE_FLAG = 6;
   localparam int CSR_DBE_FLAG = 7;
   localparam int CSR_MIN_W    = 8;

   typedef struct packed {
      logic             latch_first;
      logic             inhibit;
      logic [N_ERR-1:0] irq_en;
   } ecc_ctl_t;
endpackage

// File: rtl/ecc_reg_decode.sv
module ecc_reg_decode #(
   parameter int DATA_W    = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic              reg_sel,
   input  logic              base_hit,
   input  logic [DATA_W-1:0] csr_val,
   input  logic [DATA_W-1:0] esr_val,
   output logic              csr_wr,
   output logic              esr_wr,
   output logic [DATA_W-1:0] rdata
);
   logic              rd_hit;
   logic [DATA_W-1:0] sel_val;

   assign csr_wr  = io_wr & base_hit & reg_sel;
   assign esr_wr  = io_wr & base_hit & ~reg_sel;
   assign rd_hit  = io_rd & base_hit;
   assign sel_val = reg_sel ? csr_val : esr_val;

   generate
      if (IDLE_ZERO) begin : g_gated
         assign rdata = rd_hit ? sel_val : '0;
      end else begin : g_open
         assign rdata = sel_val;
      end
   endgenerate
endmodule

// File: rtl/ecc_csr_ctrl.sv
module ecc_csr_ctrl
   import ecc_reg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              csr_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N_ERR-1:0]  err_stb,
   input  logic              pwr_fail,
   output ecc_ctl_t          ctl,
   output logic [N_ERR-1:0]  err_flag,
   output logic              pf_flag,
   output logic              rearm
);
   logic pf_prev;
   logic pf_edge;
   logic pf_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (init) begin
         ctl <= '0;
      end else if (csr_wr) begin
         ctl.latch_first <= wdata[CSR_LATCH];
         ctl.inhibit     <= wdata[CSR_INHIBIT];
         ctl.irq_en      <= wdata[CSR_SBE_EN +: N_ERR];
      end
   end

   generate
      for (genvar i = 0; i < N_ERR; i++) begin : g_flag
         logic flag_q;
         logic set_c;
         logic clr_c;
         assign set_c = err_stb[i] & ctl.irq_en[i];
         assign clr_c = csr_wr & ~wdata[CSR_SBE_EN + i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag_q <= 1'b0;
            else if (init)   flag_q <= 1'b0;
            else if (clr_c)  flag_q <= 1'b0;
            else if (set_c)  flag_q <= 1'b1;
         end
         assign err_flag[i] = flag_q;
      end
   endgenerate

   assign pf_edge = pwr_fail & ~pf_prev;
   assign pf_clr  = csr_wr & wdata[CSR_PF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_prev <= 1'b0;
         pf_flag <= 1'b0;
      end else begin
         pf_prev <= pwr_fail;
         if (init)         pf_flag <= 1'b0;
         else if (pf_clr)  pf_flag <= 1'b0;
         else if (pf_edge) pf_flag <= 1'b1;
      end
   end

   assign rearm = csr_wr & wdata[CSR_LATCH];
endmodule

// File: rtl/ecc_esr_capture.sv
module ecc_esr_capture #(
   parameter int SYN_W  = 6,
   parameter int BANK_W = 2,
   localparam int ESR_W = SYN_W + BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              esr_wr,
   input  logic              err_any,
   input  logic [SYN_W-1:0]  err_syn,
   input  logic [BANK_W-1:0] err_bank,
   input  logic              latch_first,
   input  logic              rearm,
   output logic [ESR_W-1:0]  esr_val,
   output logic              armed
);
   logic take;
   logic drop_arm;

   assign take     = err_any & ~esr_wr & (~latch_first | armed);
   assign drop_arm = take & latch_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      esr_val <= '0;
      else if (init)   esr_val <= '0;
      else if (esr_wr) esr_val <= '0;
      else if (take)   esr_val <= {err_bank, err_syn};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed <= 1'b1;
      else if (init)     armed <= 1'b1;
      else if (rearm)    armed <= 1'b1;
      else if (drop_arm) armed <= 1'b0;
   end
endmodule

// File: rtl/ecc_status_regs.sv
module ecc_status_regs
   import ecc_reg_pkg::*;
#(
   parameter int SYN_W     = 6,
   parameter int BANK_W    = 2,
   parameter bit IDLE_ZERO = 1'b1,
   localparam int DATA_W   = SYN_W + BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic              reg_sel,
   input  logic              base_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              sbe_stb,
   input  logic              dbe_stb,
   input  logic [SYN_W-1:0]  err_syn,
   input  logic [BANK_W-1:0] err_bank,
   input  logic              pwr_fail,
   output logic              irq_sbe,
   output logic              irq_dbe,
   output logic              corr_inhibit,
   output logic              latch_first
);
   generate
      if (DATA_W < CSR_MIN_W) begin : g_bad_width
         $error("ecc_status_regs: SYN_W + BANK_W must be at least 8");
      end
   endgenerate

   logic              csr_wr;
   logic              esr_wr;
   logic              rearm;
   logic              armed;
   logic              pf_flag;
   logic [N_ERR-1:0]  err_flag;
   logic [N_ERR-1:0]  err_stb;
   ecc_ctl_t          ctl;
   logic [DATA_W-1:0] csr_val;
   logic [DATA_W-1:0] esr_val;

   assign err_stb[ERR_SBE] = sbe_stb;
   assign err_stb[ERR_DBE] = dbe_stb;

   ecc_reg_decode #(.DATA_W(DATA_W), .IDLE_ZERO(IDLE_ZERO)) u_decode (
      .io_rd    (io_rd),
      .io_wr    (io_wr),
      .reg_sel  (reg_sel),
      .base_hit (base_hit),
      .csr_val  (csr_val),
      .esr_val  (esr_val),
      .csr_wr   (csr_wr),
      .esr_wr   (esr_wr),
      .rdata    (rdata)
   );

   ecc_csr_ctrl #(.DATA_W(DATA_W)) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (init),
      .csr_wr   (csr_wr),
      .wdata    (wdata),
      .err_stb  (err_stb),
      .pwr_fail (pwr_fail),
      .ctl      (ctl),
      .err_flag (err_flag),
      .pf_flag  (pf_flag),
      .rearm    (rearm)
   );

   ecc_esr_capture #(.SYN_W(SYN_W), .BANK_W(BANK_W)) u_esr (
      .clk         (clk),
      .rst_n       (rst_n),
      .init        (init),
      .esr_wr      (esr_wr),
      .err_any     (sbe_stb | dbe_stb),
      .err_syn     (err_syn),
      .err_bank    (err_bank),
      .latch_first (ctl.latch_first),
      .rearm       (rearm),
      .esr_val     (esr_val),
      .armed       (armed)
   );

   always_comb begin
      csr_val               = '0;
      csr_val[CSR_SBE_EN]   = ctl.irq_en[ERR_SBE];
      csr_val[CSR_DBE_EN]   = ctl.irq_en[ERR_DBE];
      csr_val[CSR_INHIBIT]  = ctl.inhibit;
      csr_val[CSR_LATCH]    = ctl.latch_first;
      csr_val[CSR_PF]       = pf_flag;
      csr_val[CSR_SBE_FLAG] = err_flag[ERR_SBE];
      csr_val[CSR_DBE_FLAG] = err_flag[ERR_DBE];
   end

   assign irq_sbe      = err_flag[ERR_SBE] & ctl.irq_en[ERR_SBE];
   assign irq_dbe      = err_flag[ERR_DBE] & ctl.irq_en[ERR_DBE];
   assign corr_inhibit = ctl.inhibit;
   assign latch_first  = ctl.latch_first;
endmodule

// File: rtl/ecc_status_regs_chk.sv
module ecc_status_regs_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init,
   input logic              csr_wr,
   input logic              esr_wr,
   input logic [DATA_W-1:0] wdata,
   input logic              pwr_fail,
   input logic              pf_flag,
   input logic              armed,
   input logic              latch_first,
   input logic [DATA_W-1:0] esr_val,
   input logic              irq_sbe,
   input logic              irq_dbe
);
   // R4: writing an enable to 0 silences its interrupt next cycle
   p_sbe_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && !wdata[0]) |=> !irq_sbe);
   p_dbe_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && !wdata[1]) |=> !irq_dbe);
   // R8: an ESR write empties the ESR
   p_esr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      esr_wr |=> (esr_val == '0));
   // R6: a disarmed latch-first capture holds its contents
   p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_first && !armed && !esr_wr && !init) |=> $stable(esr_val));
   // R9: a power-fail edge sets the flag unless cleared
   p_pf_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwr_fail) && !(csr_wr && wdata[4]) && !init) |=> pf_flag);
   // R11: the clearing write beats a same-cycle edge
   p_pf_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && wdata[4]) |=> !pf_flag);
   // R10: init empties everything
   p_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (!irq_sbe && !irq_dbe && !pf_flag && esr_val == '0 && armed));
endmodule

bind ecc_status_regs ecc_status_regs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .init        (init),
   .csr_wr      (csr_wr),
   .esr_wr      (esr_wr),
   .wdata       (wdata),
   .pwr_fail    (pwr_fail),
   .pf_flag     (pf_flag),
   .armed       (armed),
   .latch_first (latch_first),
   .esr_val     (esr_val),
   .irq_sbe     (irq_sbe),
   .irq_dbe     (irq_dbe)
);

// File: tb/ecc_status_regs_tb.sv
module ecc_status_regs_tb;
   logic       clk = 1'b0;
   logic       rst_n, init, io_rd, io_wr, reg_sel, base_hit;
   logic [7:0] wdata, rdata;
   logic       sbe_stb, dbe_stb, pwr_fail;
   logic [5:0] err_syn;
   logic [1:0] err_bank;
   logic       irq_sbe, irq_dbe, corr_inhibit, latch_first;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [1:0] m_en, m_flag;
   logic       m_inh, m_lf, m_pf, m_prev, m_armed;
   logic [7:0] m_esr;

   always #10 clk = ~clk;

   ecc_status_regs u_dut (
      .clk(clk), .rst_n(rst_n), .init(init), .io_rd(io_rd), .io_wr(io_wr),
      .reg_sel(reg_sel), .base_hit(base_hit), .wdata(wdata), .rdata(rdata),
      .sbe_stb(sbe_stb), .dbe_stb(dbe_stb), .err_syn(err_syn), .err_bank(err_bank),
      .pwr_fail(pwr_fail), .irq_sbe(irq_sbe), .irq_dbe(irq_dbe),
      .corr_inhibit(corr_inhibit), .latch_first(latch_first)
   );

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_csr();
      return {m_flag[1], m_flag[0], 1'b0, m_pf, m_lf, m_inh, m_en};
   endfunction

   task automatic model_reset();
      m_en = 0; m_flag = 0; m_inh = 0; m_lf = 0; m_pf = 0;
      m_prev = 0; m_armed = 1; m_esr = 0;
   endtask

   task automatic model_clock();
      logic cw, ew, any, n_armed;
      cw  = io_wr && base_hit && reg_sel;
      ew  = io_wr && base_hit && !reg_sel;
      any = sbe_stb || dbe_stb;
      if (init) begin
         model_reset();
         m_prev = pwr_fail;
         return;
      end
      n_armed = m_armed;
      if (cw && wdata[3]) n_armed = 1;
      else if (!ew && any && m_lf && m_armed) n_armed = 0;
      if (ew) m_esr = 0;
      else if (any && (!m_lf || m_armed)) m_esr = {err_bank, err_syn};
      for (int i = 0; i < 2; i++) begin
         logic stb;
         stb = (i == 0) ? sbe_stb : dbe_stb;
         if (cw && !wdata[i]) m_flag[i] = 0;
         else if (stb && m_en[i]) m_flag[i] = 1;
      end
      if (cw && wdata[4]) m_pf = 0;
      else if (pwr_fail && !m_prev) m_pf = 1;
      m_prev = pwr_fail;
      if (cw) begin
         m_en = wdata[1:0]; m_inh = wdata[2]; m_lf = wdata[3];
      end
      m_armed = n_armed;
   endtask

   task automatic step();
      #2;
      if (io_rd && base_hit) begin
         if (reg_sel) chk("R2 csr read", rdata, exp_csr());
         else         chk("R7 esr read", rdata, m_esr);
      end else begin
         chk("R1 idle read", rdata, 8'h00);
      end
      @(posedge clk);
      model_clock();
      @(negedge clk);
      chk("R5 irq outputs", {6'b0, irq_dbe, irq_sbe}, {6'b0, m_flag & m_en});
      chk("R12 control outputs", {6'b0, latch_first, corr_inhibit}, {6'b0, m_lf, m_inh});
   endtask

   task automatic idle();
      init = 0; io_rd = 0; io_wr = 0; reg_sel = 0; base_hit = 0; wdata = 0;
      sbe_stb = 0; dbe_stb = 0; err_syn = 0; err_bank = 0;
   endtask

   task automatic wr(logic sel, logic [7:0] d);
      idle(); io_wr = 1; base_hit = 1; reg_sel = sel; wdata = d;
   endtask

   task automatic rd_const(logic sel, logic [7:0] exp, string tag);
      idle(); io_rd = 1; base_hit = 1; reg_sel = sel;
      #1 chk(tag, rdata, exp);
      step();
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(); pwr_fail = 0; rst_n = 0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      rd_const(1, 8'h00, "R10 csr after reset");
      rd_const(0, 8'h00, "R10 esr after reset");
      // R3 / R6 latch-first capture
      wr(1, 8'hEB); step();
      rd_const(1, 8'h0B, "R3 stored bits");
      idle(); sbe_stb = 1; err_syn = 6'h15; err_bank = 2'b10; step();
      idle(); sbe_stb = 1; err_syn = 6'h2A; err_bank = 2'b01; step();
      chk("R4 flag set", {7'b0, irq_sbe}, 8'h01);
      rd_const(0, 8'h95, "R6 first error held");
      // R11 enable clear vs strobe, plus re-arm
      wr(1, 8'h0A); sbe_stb = 1; err_syn = 6'h01; step();
      rd_const(1, 8'h0A, "R11 enable clear wins");
      idle(); sbe_stb = 1; err_syn = 6'h03; err_bank = 2'b11; step();
      rd_const(1, 8'h0A, "R4 strobe while disabled");
      rd_const(0, 8'hC3, "R6 rearmed capture");
      // R8 / R11 ESR write vs strobe
      wr(0, 8'hFF); dbe_stb = 1; err_syn = 6'h3F; err_bank = 2'b11; step();
      rd_const(0, 8'h00, "R8 esr write clears");
      // R1 unqualified write
      wr(1, 8'h00); base_hit = 0; step();
      rd_const(1, 8'h8A, "R1 write without base hit");
      // R11 power-fail clear vs edge, then R9
      wr(1, 8'h17); pwr_fail = 1; step();
      rd_const(1, 8'h87, "R11 pf clear wins");
      pwr_fail = 0; idle(); step();
      pwr_fail = 1; idle(); step();
      rd_const(1, 8'h97, "R9 pf edge sets");
      // R6 mode 0 updates each time
      idle(); sbe_stb = 1; err_syn = 6'h05; step();
      idle(); dbe_stb = 1; err_syn = 6'h06; err_bank = 2'b01; step();
      rd_const(0, 8'h46, "R6 every error reloads");
      // R10 init
      idle(); init = 1; step();
      rd_const(1, 8'h00, "R10 csr after init");
      rd_const(0, 8'h00, "R10 esr after init");
      // random stimulus
      void'($urandom(32'd1234));
      for (int k = 0; k < 4000; k++) begin
         idle();
         io_wr    = ($urandom % 5) == 0;
         io_rd    = ($urandom % 2) == 0;
         base_hit = ($urandom % 5) != 0;
         reg_sel  = $urandom % 2;
         wdata    = $urandom;
         sbe_stb  = ($urandom % 6) == 0;
         dbe_stb  = ($urandom % 8) == 0;
         err_syn  = $urandom;
         err_bank = $urandom;
         init     = ($urandom % 150) == 0;
         if (($urandom % 10) == 0) pwr_fail = ~pwr_fail;
         step();
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule